// File: doc/BRIEF.md
# Service-Timed Watchdog with Prescaler Chain

This block watches over a running system and forces a reset when software stops servicing it. A free-running prescaler divides the oscillator clock. A carry taken from that prescaler advances a small watchdog counter. When the counter rolls over, the block drives an active-low reset output low for a fixed number of oscillator cycles and latches a flag that records the watchdog as the reset cause.

Software keeps the system alive by writing the service register. A write clears the watchdog counter and the upper prescaler stages. The lowest four prescaler stages keep counting, so the time left after a service is a power of two minus a value from 0 to 15. A rate input chooses which prescaler carry drives the counter, which gives a short window or a long one.

After power-on the prescaler first runs one full start-up lap, and the watchdog stays idle during that lap. A stop-entry pulse clears the whole prescaler. An internal reset clears the prescaler and the counter. A disable input for test or monitor operation blocks the reset. Reading the service register returns a constant byte and leaves the counters alone.

Top module: `svc_watchdog`

## Requirements
- R1: With `rate_sel_i` high, the counter advances each time the low 7 prescaler bits are all ones. The reset therefore starts 8192 − v cycles after a service write, where v (0..15) is the value of the low four prescaler bits just after that write.
- R2: With `rate_sel_i` low, the counter advances on the carry out of the full prescaler. The reset starts 2^(PRE_W+WD_W) − v cycles after a service write (2^18 − v at the defaults).
- R3: A `svc_wr_i` strobe clears the watchdog counter and prescaler bits [PRE_W-1:4]. Prescaler bits [3:0] keep incrementing. Servicing at intervals shorter than the window prevents any reset.
- R4: On overflow, `rst_n_o` goes low starting the cycle after the overflow edge and stays low for exactly PULSE_LEN (32) cycles.
- R5: `rd_data_o` equals CONST_BYTE while `svc_rd_i` is high and 0 otherwise. A read has no effect on timing.
- R6: A `stop_i` strobe clears the whole prescaler and leaves the counter unchanged. With the counter at zero, the next reset comes 8192 cycles (short rate) after the stop edge.
- R7: After `por_i` is released, the prescaler runs for 2^PRE_W cycles and then wraps to zero. During that time the counter is held at zero and service and stop strobes are ignored. The first unserviced reset therefore starts 2^PRE_W + 8192 cycles after release (short rate).
- R8: An `irst_i` strobe clears both the prescaler and the counter, ahead of any other strobe. It leaves the reset pulse and the cause flag untouched.
- R9: While `wd_dis_i` is high, an overflow produces neither a reset pulse nor a cause flag.
- R10: `cause_o` is set by an overflow and holds until `por_i` or, when READ_CLEAR is 1, a `stat_rd_i` strobe. A set in the same cycle as a clear wins.
- R11: A service strobe on the same edge as an overflow suppresses the reset and clears the counter.
- R12: While `por_i` is high, `rst_n_o` is high, `cause_o` is 0 and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| irst_i | input | 1 | Internal reset strobe, synchronous |
| svc_wr_i | input | 1 | Service register write strobe |
| svc_rd_i | input | 1 | Service register read strobe |
| rd_data_o | output | 8 | Read data of the service register |
| rate_sel_i | input | 1 | 1 = short window, 0 = long window |
| stop_i | input | 1 | Stop-entry strobe |
| wd_dis_i | input | 1 | Disables reset generation (test mode) |
| stat_rd_i | input | 1 | Status read strobe (clears flag if enabled) |
| cause_o | output | 1 | Watchdog reset-cause flag |
| rst_n_o | output | 1 | Reset request, active low |

## Verification
The properties assume the following about the inputs:
- `por_i` is the only asynchronous input.
- Every other strobe is synchronous and is sampled at the rising edge.
- The watchdog window is much longer than the reset pulse, so a new overflow can never land inside a running pulse.

The stimulus drives every input on the falling edge and keeps each strobe to one cycle. It changes `rate_sel_i` only just before an internal reset, so a window never mixes two carry taps. Every test starts from an internal reset, which makes the prescaler phase known to the bench when it computes the expected reset cycle.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

  // Operation applied to the prescaler on the next edge
  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_FREE  = 3'd1,
    PS_SVC   = 3'd2,
    PS_STOP  = 3'd3,
    PS_CLEAR = 3'd4
  } ps_op_e;

  // Priority: internal reset, start-up lap, stop entry, service, run
  function automatic ps_op_e ps_pick(input logic irst, input logic startup,
                                     input logic stop, input logic svc);
    if (irst)    return PS_CLEAR;
    if (startup) return PS_FREE;
    if (stop)    return PS_STOP;
    if (svc)     return PS_SVC;
    return PS_RUN;
  endfunction

  // Watchdog counter is cleared by internal reset, held in start-up, cleared by service
  function automatic logic wd_clear(input logic irst, input logic startup,
                                    input logic svc);
    return irst | startup | svc;
  endfunction

endpackage

// File: rtl/svc_wdog_prescaler.sv
module svc_wdog_prescaler
  import svc_wdog_pkg::*;
#(
  parameter int PRE_W     = 12,
  parameter int SHORT_TAP = 7,
  parameter int KEEP_W    = 4
) (
  input  logic             clk,
  input  logic             por,
  input  ps_op_e           op,
  input  logic             rate_sel,
  output logic [PRE_W-1:0] pre_q,
  output logic             tick,
  output logic             startup_q
);

  // carry[i] is high when prescaler bits [i:0] are all ones
  logic [PRE_W-1:0] carry;

  assign carry[0] = pre_q[0];
  for (genvar i = 1; i < PRE_W; i++) begin : g_carry
    assign carry[i] = carry[i-1] & pre_q[i];
  end

  function automatic logic [PRE_W-1:0] f_next(input logic [PRE_W-1:0] cur,
                                               input ps_op_e o);
    logic [PRE_W-1:0] inc;
    inc = cur + 1'b1;
    case (o)
      PS_CLEAR, PS_STOP: return '0;
      PS_SVC: begin
        inc[PRE_W-1:KEEP_W] = '0;
        return inc;
      end
      default: return inc;
    endcase
  endfunction

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      pre_q     <= '0;
      startup_q <= 1'b1;
    end else begin
      pre_q <= f_next(pre_q, op);
      if (startup_q && carry[PRE_W-1]) startup_q <= 1'b0;
    end
  end

  assign tick = !startup_q && (rate_sel ? carry[SHORT_TAP-1] : carry[PRE_W-1]);

endmodule

// File: rtl/svc_wdog_counter.sv
module svc_wdog_counter #(
  parameter int WD_W = 6
) (
  input  logic            clk,
  input  logic            por,
  input  logic            clr,
  input  logic            tick,
  input  logic            mask,
  output logic [WD_W-1:0] cnt_q,
  output logic            ovf
);

  // Overflow: rollover on a tick, unless cleared this edge or masked
  assign ovf = tick && (&cnt_q) && !clr && !mask;

  always_ff @(posedge clk or posedge por) begin
    if (por)       cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/svc_wdog_pulse.sv
module svc_wdog_pulse #(
  parameter int PULSE_LEN = 32
) (
  input  logic clk,
  input  logic por,
  input  logic fire,
  output logic rst_n
);

  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or posedge por) begin
    if (por)                 left_q <= '0;
    else if (fire)           left_q <= CW'(PULSE_LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign rst_n = (left_q == '0);

endmodule

// File: rtl/svc_wdog_flag.sv
module svc_wdog_flag #(
  parameter bit READ_CLEAR = 1'b1
) (
  input  logic clk,
  input  logic por,
  input  logic set,
  input  logic rd,
  output logic flag_q
);

  logic clr;
  assign clr = READ_CLEAR ? rd : 1'b0;

  always_ff @(posedge clk or posedge por) begin
    if (por)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wdog_pkg::*;
#(
  parameter int         PRE_W      = 12,
  parameter int         SHORT_TAP  = 7,
  parameter int         WD_W       = 6,
  parameter int         KEEP_W     = 4,
  parameter int         PULSE_LEN  = 32,
  parameter logic [7:0] CONST_BYTE = 8'h5C,
  parameter bit         READ_CLEAR = 1'b1
) (
  input  logic       clk_osc,
  input  logic       por_i,
  input  logic       irst_i,
  input  logic       svc_wr_i,
  input  logic       svc_rd_i,
  output logic [7:0] rd_data_o,
  input  logic       rate_sel_i,
  input  logic       stop_i,
  input  logic       wd_dis_i,
  input  logic       stat_rd_i,
  output logic       cause_o,
  output logic       rst_n_o
);

  // Named internal events, visible to the bound checker
  ps_op_e            op_w;
  logic [PRE_W-1:0]  pre_w;
  logic              tick_w;
  logic              startup_w;
  logic              wd_clr_w;
  logic [WD_W-1:0]   wdc_w;
  logic              ovf_w;

  assign op_w     = ps_pick(irst_i, startup_w, stop_i, svc_wr_i);
  assign wd_clr_w = wd_clear(irst_i, startup_w, svc_wr_i);

  svc_wdog_prescaler #(
    .PRE_W(PRE_W), .SHORT_TAP(SHORT_TAP), .KEEP_W(KEEP_W)
  ) u_pre (
    .clk(clk_osc), .por(por_i), .op(op_w), .rate_sel(rate_sel_i),
    .pre_q(pre_w), .tick(tick_w), .startup_q(startup_w)
  );

  svc_wdog_counter #(.WD_W(WD_W)) u_cnt (
    .clk(clk_osc), .por(por_i), .clr(wd_clr_w), .tick(tick_w),
    .mask(wd_dis_i), .cnt_q(wdc_w), .ovf(ovf_w)
  );

  svc_wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk_osc), .por(por_i), .fire(ovf_w), .rst_n(rst_n_o)
  );

  svc_wdog_flag #(.READ_CLEAR(READ_CLEAR)) u_flag (
    .clk(clk_osc), .por(por_i), .set(ovf_w), .rd(stat_rd_i), .flag_q(cause_o)
  );

  assign rd_data_o = svc_rd_i ? CONST_BYTE : 8'h00;

endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int PRE_W     = 12,
  parameter int WD_W      = 6,
  parameter int KEEP_W    = 4,
  parameter int PULSE_LEN = 32
) (
  input logic             clk,
  input logic             por,
  input logic             irst,
  input logic             svc_wr,
  input logic             stop,
  input logic             wd_dis,
  input logic             rst_n,
  input logic             cause,
  input logic             startup,
  input logic [PRE_W-1:0] pre_q,
  input logic [WD_W-1:0]  wdc_q
);

  // Length of the current low run of the reset output
  logic [15:0] lowrun;
  always_ff @(posedge clk or posedge por) begin
    if (por)         lowrun <= '0;
    else if (!rst_n) lowrun <= lowrun + 1'b1;
    else             lowrun <= '0;
  end

  a_r4_pulse_len: assert property (@(posedge clk) disable iff (por)
    $rose(rst_n) |-> (lowrun == 16'(PULSE_LEN)));

  a_r4_pulse_bound: assert property (@(posedge clk) disable iff (por)
    !rst_n |-> (lowrun < 16'(PULSE_LEN)));

  a_r3_partial_clear: assert property (@(posedge clk) disable iff (por)
    (svc_wr && !irst && !stop && !startup) |=>
      (pre_q[PRE_W-1:KEEP_W] == '0) &&
      (pre_q[KEEP_W-1:0] == $past(pre_q[KEEP_W-1:0]) + 1'b1) &&
      (wdc_q == '0));

  a_r6_stop_clear: assert property (@(posedge clk) disable iff (por)
    (stop && !irst && !startup) |=> (pre_q == '0));

  a_r7_startup_hold: assert property (@(posedge clk) disable iff (por)
    startup |-> (wdc_q == '0));

  a_r8_irst_clear: assert property (@(posedge clk) disable iff (por)
    irst |=> (pre_q == '0) && (wdc_q == '0));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (por)
    (wd_dis && rst_n) |=> rst_n);

  a_r10_cause_on_reset: assert property (@(posedge clk) disable iff (por)
    $fell(rst_n) |-> cause);

  a_r11_service_wins: assert property (@(posedge clk) disable iff (por)
    (svc_wr && rst_n) |=> rst_n);

  always_comb begin
    if (por) a_r12_por_state: assert (rst_n && !cause);
  end

endmodule

bind svc_watchdog svc_watchdog_chk #(
  .PRE_W(PRE_W), .WD_W(WD_W), .KEEP_W(KEEP_W), .PULSE_LEN(PULSE_LEN)
) chk_i (
  .clk(clk_osc), .por(por_i), .irst(irst_i), .svc_wr(svc_wr_i),
  .stop(stop_i), .wd_dis(wd_dis_i), .rst_n(rst_n_o), .cause(cause_o),
  .startup(startup_w), .pre_q(pre_w), .wdc_q(wdc_w)
);

// File: tb/svc_watchdog_tb_top.sv
module svc_watchdog_tb_top;

  localparam int         PW    = 9;
  localparam int         BOOT  = 1 << PW;
  localparam int         SHORT = 8192;
  localparam int         LONG  = 1 << (PW + 6);
  localparam int         PL    = 32;
  localparam logic [7:0] RB    = 8'hC3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       por = 1'b1, irst = 1'b0, svc_wr = 1'b0, svc_rd = 1'b0;
  logic       rate_sel = 1'b1, stop = 1'b0, wd_dis = 1'b0, stat_rd = 1'b0;
  logic [7:0] rd_data;
  logic       cause, rst_n;

  svc_watchdog #(.PRE_W(PW), .CONST_BYTE(RB)) dut_i (
    .clk_osc(clk), .por_i(por), .irst_i(irst), .svc_wr_i(svc_wr),
    .svc_rd_i(svc_rd), .rd_data_o(rd_data), .rate_sel_i(rate_sel),
    .stop_i(stop), .wd_dis_i(wd_dis), .stat_rd_i(stat_rd),
    .cause_o(cause), .rst_n_o(rst_n)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, fall_cnt = 0;
  bit done = 1'b0;

  typedef struct { int at; string req; } exp_t;
  exp_t exq[$];
  exp_t cur_e;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_reset(input int at, input string req);
    exp_t e;
    e.at = at;
    e.req = req;
    exq.push_back(e);
  endtask

  // Monitor: pops the expected reset start and measures the pulse width
  logic prev_rst = 1'b1;
  int   lowcnt = 0;
  always @(negedge clk) begin
    if (!por) begin
      if (prev_rst && !rst_n) begin
        fall_cnt++;
        lowcnt = 1;
        if (exq.size() == 0) check(1'b0, "R3/R9/R11", "unexpected reset at cycle", cyc, -1);
        else begin
          cur_e = exq.pop_front();
          check(cyc == cur_e.at, cur_e.req, "reset start cycle", cyc, cur_e.at);
        end
      end else if (!rst_n) lowcnt++;
      else if (!prev_rst) check(lowcnt == PL, "R4", "reset low width", lowcnt, PL);
      prev_rst = rst_n;
    end
  end

  task automatic tick_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_irst(output int e);
    irst = 1'b1;
    e = cyc + 1;
    @(negedge clk);
    irst = 1'b0;
  endtask

  task automatic svc_at(input int s);
    tick_to(s - 1);
    svc_wr = 1'b1;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic stop_at(input int s);
    tick_to(s - 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic clear_cause();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check(cause == 1'b0, "R10", "cause after status read", cause, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    int p, e0, e1, s, fc;
    repeat (3) @(negedge clk);
    // R12: state under power-on reset
    check(rst_n == 1'b1, "R12", "rst_n under por", rst_n, 1);
    check(cause == 1'b0, "R12", "cause under por", cause, 0);
    check(rd_data == 8'h00, "R5", "rd_data idle", rd_data, 0);
    por = 1'b0;
    p = cyc;

    // R7: start-up lap, service and stop ignored inside it
    expect_reset(p + BOOT + SHORT, "R7");
    svc_at(p + 100);
    stop_at(p + 200);
    tick_to(p + BOOT + SHORT + 40);
    check(cause == 1'b1, "R10", "cause after reset", cause, 1);
    tick_to(cyc + 50);
    check(cause == 1'b1, "R10", "cause sticky", cause, 1);
    clear_cause();

    // R1 and R5: v = 21 mod 16 = 5, reads in between
    do_irst(e0);
    s = e0 + 21;
    svc_at(s);
    expect_reset(s + SHORT - 5, "R1");
    tick_to(s + 100);
    svc_rd = 1'b1;
    @(negedge clk);
    check(rd_data == RB, "R5", "read constant", rd_data, RB);
    @(negedge clk);
    svc_rd = 1'b0;
    #1;
    check(rd_data == 8'h00, "R5", "rd_data after read", rd_data, 0);
    tick_to(s + SHORT + 40);
    clear_cause();

    // R1: v = 0
    do_irst(e0);
    s = e0 + 32;
    svc_at(s);
    expect_reset(s + SHORT, "R1");
    tick_to(s + SHORT + 40);
    clear_cause();

    // R6: stop clears the whole prescaler (service would give 8192-5)
    do_irst(e0);
    stop_at(e0 + 37);
    expect_reset(e0 + 37 + SHORT, "R6");
    tick_to(e0 + 37 + SHORT + 40);
    clear_cause();

    // R8: internal reset restarts the full window
    do_irst(e0);
    tick_to(e0 + 3000);
    do_irst(e1);
    expect_reset(e1 + SHORT, "R8");
    tick_to(e1 + SHORT + 40);
    clear_cause();

    // R9: disabled watchdog stays quiet across its overflow
    do_irst(e0);
    fc = fall_cnt;
    tick_to(e0 + 100);
    wd_dis = 1'b1;
    tick_to(e0 + 8300);
    wd_dis = 1'b0;
    do_irst(e1);
    check(fall_cnt == fc, "R9", "resets while disabled", fall_cnt - fc, 0);
    check(cause == 1'b0, "R9", "cause while disabled", cause, 0);

    // R11: service on the overflow edge wins, counter cleared (v = 0)
    do_irst(e0);
    svc_at(e0 + SHORT);
    expect_reset(e0 + SHORT + SHORT, "R11");
    tick_to(e0 + 2 * SHORT + 40);
    clear_cause();

    // R3: regular servicing keeps the system alive
    do_irst(e0);
    fc = fall_cnt;
    svc_at(e0 + 7000);
    svc_at(e0 + 14000);
    tick_to(e0 + 20000);
    do_irst(e1);
    check(fall_cnt == fc, "R3", "resets with regular service", fall_cnt - fc, 0);

    // R2: long window, v = 3
    rate_sel = 1'b0;
    do_irst(e0);
    s = e0 + 3;
    svc_at(s);
    expect_reset(s + LONG - 3, "R2");
    tick_to(s + LONG + 40);
    check(cause == 1'b1, "R10", "cause after long reset", cause, 1);
    check(exq.size() == 0, "R2", "expected resets left", exq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired: got cycle %0d expected below %0d", cyc, 195000);
      finish_run();
    end
  end

endmodule